// File: doc/BRIEF.md
# Zero-Suppressed Hit Readout Serializer

This block empties the hit memory of a 64-channel front-end chip onto one serial line that several chips share. A chip may drive the line only while it holds the token. A one-cycle pulse on `token_in` starts a readout. When the last bit has gone out, the block pulses `token_out` so that the next chip on the chain can begin.

A readout always opens with a chip-identity word. After it, the block sends one header word for each channel that holds at least one stored event, taking channels in ascending order. Each header is followed by that channel's events, oldest first. Channels with no events are skipped. Words are 16 bits long and go out MSB first. Bit 15 gives the word type and bit 0 is an even-parity bit. Event data comes in through an asynchronous read port that the block addresses by channel and event index. A configuration input decides what a chip with no events does: it either hands the token on at once or sends only its identity word.

The controller has five states. `ST_IDLE` waits for the token. `ST_CHIPID`, `ST_HEADER` and `ST_EVENT` each shift out one word; at the last bit of a word the controller loads the next word in the same cycle. `ST_HANDOFF` drives the one-cycle token pulse and then returns to `ST_IDLE`. The transitions are:
- start: `ST_IDLE` to `ST_CHIPID` when the token arrives and there is something to send.
- skip: `ST_IDLE` to `ST_HANDOFF` when the token arrives, no events are stored and the identity-only option is off.
- first channel: `ST_CHIPID` to `ST_HEADER` when a hit channel exists.
- into events: `ST_HEADER` to `ST_EVENT`.
- next event: `ST_EVENT` to `ST_EVENT` while events of the current channel remain.
- next channel: `ST_EVENT` to `ST_HEADER` when another hit channel follows.
- finish: `ST_CHIPID` or `ST_EVENT` to `ST_HANDOFF` when nothing remains to send.
- rest: `ST_HANDOFF` to `ST_IDLE`.

Top module: `zs_readout_serializer`

## Requirements
- R1: After reset, `tx_en`, `sdata` and `token_out` are all 0.
- R2: A `token_in` pulse sampled in idle with data to send raises `tx_en` in the following cycle. `tx_en` then stays high without a gap for exactly 16 cycles per word sent.
- R3: The first word is the identity word {1, 6'b0, chip_id[7:0], parity}. Every word is sent MSB first, one bit per clock.
- R4: A channel header is {1, channel[5:0], count[3:0], 4'b0, parity}.
- R5: Each header is followed by that channel's events in index order 0..count-1. Each event is sent as the data word {0, timestamp[11:0], disc[1:0], parity}, read from the memory port at (channel, index).
- R6: Only channels with a nonzero count are sent, and they are sent in ascending channel order.
- R7: Bit 0 of every word makes the XOR of all 16 bits equal to 0.
- R8: With no stored events and `id_always`=0, no bit is sent (`tx_en` stays 0) and `token_out` pulses in the cycle after `token_in` was sampled.
- R9: With no stored events and `id_always`=1, only the identity word is sent.
- R10: `token_out` is high for exactly one cycle, the cycle right after the last bit with `tx_en` high.
- R11: A per-channel count above MAX_EV (8) is treated as MAX_EV, both in the header and in the number of events sent.
- R12: A `token_in` pulse that arrives during a readout is ignored. The stream and the single `token_out` pulse are unchanged.
- R13: `sdata` is 0 whenever `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| token_in | input | 1 | One-cycle pulse granting the line to this chip |
| id_always | input | 1 | 1: send the identity word even when no events are stored |
| chip_id | input | 8 | Identity of this chip |
| ev_count | input | 256 | Stored event count per channel, 4 bits each; channel c at [4c+3:4c] |
| mem_ch | output | 6 | Channel address of the event read port |
| mem_ev | output | 4 | Event index address of the event read port |
| mem_ts | input | 12 | Timestamp of the addressed event (asynchronous read) |
| mem_disc | input | 2 | Encoded discriminator bits of the addressed event |
| sdata | output | 1 | Serial data, MSB first |
| tx_en | output | 1 | High while this chip drives a bit onto the line |
| token_out | output | 1 | One-cycle pulse passing the token on |

## Verification
The bench builds the block with its defaults: NUM_CH=64 and MAX_EV=8. This makes the full-length readout reachable: every channel holds 8 events, which gives 577 words, and the bench checks it bit for bit. The same settings also reach the top channel 63, which exercises the scan start that would wrap past the last channel, and counts of 9 to 15, which test saturation. Random sparse hit patterns with random identities and configurations check header ordering and event ordering. Directed runs cover the two empty-chip options and a token pulse that arrives during a readout.

// File: rtl/zs_rdo_pkg.sv
package zs_rdo_pkg;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 4;
    localparam int TS_W   = 12;
    localparam int DISC_W = 2;
    localparam int ID_W   = 8;
    localparam int CHF_W  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHIPID,
        ST_HEADER,
        ST_EVENT,
        ST_HANDOFF
    } rdo_state_t;

    typedef enum logic [1:0] {
        WK_ID,
        WK_HDR,
        WK_DATA
    } word_kind_t;

    function automatic logic [WORD_W-1:0] seal_parity(input logic [WORD_W-1:0] raw);
        return {raw[WORD_W-1:1], ^raw[WORD_W-1:1]};
    endfunction
endpackage

// File: rtl/zs_rdo_chan_finder.sv
module zs_rdo_chan_finder #(
    parameter int NUM_CH = 64,
    parameter int CNT_W  = 4,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0][CNT_W-1:0] counts,
    input  logic [SEL_W:0]               start,
    output logic                         found,
    output logic [SEL_W-1:0]             chan
);
    logic [NUM_CH-1:0] eligible;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_elig
        assign eligible[g] = (counts[g] != '0) && (int'(start) <= g);
    end

    always_comb begin
        found = 1'b0;
        chan  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                chan  = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/zs_rdo_word_former.sv
module zs_rdo_word_former
    import zs_rdo_pkg::*;
(
    input  word_kind_t          kind,
    input  logic [ID_W-1:0]     chip_id,
    input  logic [CHF_W-1:0]    chan,
    input  logic [CNT_W-1:0]    count,
    input  logic [TS_W-1:0]     ts,
    input  logic [DISC_W-1:0]   disc,
    output logic [WORD_W-1:0]   word
);
    logic [WORD_W-1:0] raw;

    always_comb begin
        unique case (kind)
            WK_ID:   raw = {1'b1, 6'b0, chip_id, 1'b0};
            WK_HDR:  raw = {1'b1, chan, count, 4'b0, 1'b0};
            WK_DATA: raw = {1'b0, ts, disc, 1'b0};
            default: raw = '0;
        endcase
        word = seal_parity(raw);
    end
endmodule

// File: rtl/zs_rdo_shifter.sv
module zs_rdo_shifter #(
    parameter int W = 16,
    localparam int BC_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift_en,
    output logic         msb,
    output logic         last
);
    logic [W-1:0]    sh;
    logic [BC_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            bit_cnt <= '0;
        end else if (load) begin
            sh      <= load_word;
            bit_cnt <= '0;
        end else if (shift_en) begin
            sh      <= {sh[W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign msb  = sh[W-1];
    assign last = (bit_cnt == BC_W'(W - 1));
endmodule

// File: rtl/zs_readout_serializer.sv
module zs_readout_serializer
    import zs_rdo_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int MAX_EV = 8,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     token_in,
    input  logic                     id_always,
    input  logic [ID_W-1:0]          chip_id,
    input  logic [NUM_CH*CNT_W-1:0]  ev_count,
    output logic [SEL_W-1:0]         mem_ch,
    output logic [CNT_W-1:0]         mem_ev,
    input  logic [TS_W-1:0]          mem_ts,
    input  logic [DISC_W-1:0]        mem_disc,
    output logic                     sdata,
    output logic                     tx_en,
    output logic                     token_out
);
    rdo_state_t state, state_n;
    logic [SEL_W-1:0] cur_ch, ch_n;
    logic [CNT_W-1:0] nxt_ev, ev_n;

    logic [NUM_CH-1:0][CNT_W-1:0] eff_cnt;
    logic [NUM_CH-1:0]            has_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_clamp
        logic [CNT_W-1:0] raw_c;
        assign raw_c      = ev_count[g*CNT_W +: CNT_W];
        assign eff_cnt[g] = (raw_c > CNT_W'(MAX_EV)) ? CNT_W'(MAX_EV) : raw_c;
        assign has_hit[g] = (raw_c != '0);
    end

    logic [SEL_W:0]   scan_start;
    logic             fnd;
    logic [SEL_W-1:0] fnd_ch;

    assign scan_start = (state == ST_CHIPID) ? '0 : ({1'b0, cur_ch} + 1'b1);

    zs_rdo_chan_finder #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_finder (
        .counts (eff_cnt),
        .start  (scan_start),
        .found  (fnd),
        .chan   (fnd_ch)
    );

    word_kind_t        kind;
    logic [WORD_W-1:0] ld_word;
    logic              load;
    logic              sh_msb, sh_last;
    logic              sending;

    zs_rdo_word_former u_former (
        .kind    (kind),
        .chip_id (chip_id),
        .chan    (CHF_W'(fnd_ch)),
        .count   (eff_cnt[fnd_ch]),
        .ts      (mem_ts),
        .disc    (mem_disc),
        .word    (ld_word)
    );

    assign sending = (state == ST_CHIPID) || (state == ST_HEADER) || (state == ST_EVENT);

    zs_rdo_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (ld_word),
        .shift_en  (sending && !load),
        .msb       (sh_msb),
        .last      (sh_last)
    );

    // Next-state and word-load decisions
    always_comb begin
        state_n = state;
        ch_n    = cur_ch;
        ev_n    = nxt_ev;
        load    = 1'b0;
        kind    = WK_ID;
        unique case (state)
            ST_IDLE: begin
                if (token_in) begin
                    if ((|has_hit) || id_always) begin
                        load    = 1'b1;
                        kind    = WK_ID;
                        state_n = ST_CHIPID;
                    end else begin
                        state_n = ST_HANDOFF;
                    end
                end
            end
            ST_CHIPID: begin
                if (sh_last) begin
                    if (fnd) begin
                        load    = 1'b1;
                        kind    = WK_HDR;
                        ch_n    = fnd_ch;
                        ev_n    = '0;
                        state_n = ST_HEADER;
                    end else begin
                        state_n = ST_HANDOFF;
                    end
                end
            end
            ST_HEADER: begin
                if (sh_last) begin
                    load    = 1'b1;
                    kind    = WK_DATA;
                    ev_n    = nxt_ev + 1'b1;
                    state_n = ST_EVENT;
                end
            end
            ST_EVENT: begin
                if (sh_last) begin
                    if (nxt_ev < eff_cnt[cur_ch]) begin
                        load = 1'b1;
                        kind = WK_DATA;
                        ev_n = nxt_ev + 1'b1;
                    end else if (fnd) begin
                        load    = 1'b1;
                        kind    = WK_HDR;
                        ch_n    = fnd_ch;
                        ev_n    = '0;
                        state_n = ST_HEADER;
                    end else begin
                        state_n = ST_HANDOFF;
                    end
                end
            end
            ST_HANDOFF: state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
            nxt_ev <= '0;
        end else begin
            state  <= state_n;
            cur_ch <= ch_n;
            nxt_ev <= ev_n;
        end
    end

    // Outputs
    always_comb begin
        tx_en     = sending;
        sdata     = sending & sh_msb;
        token_out = (state == ST_HANDOFF);
        mem_ch    = cur_ch;
        mem_ev    = nxt_ev;
    end

    assert_token_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);
    assert_token_after_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> token_out);
    assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !sh_last) |=> tx_en);
    assert_even_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (^ld_word == 1'b0));
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && kind == WK_HDR && state == ST_EVENT) |-> (fnd_ch > cur_ch));
    assert_event_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVENT) |-> (nxt_ev <= CNT_W'(MAX_EV)));
endmodule

// File: tb/zs_readout_serializer_tb.sv
module zs_readout_serializer_tb;
    localparam int NUM_CH = 64;
    localparam int MAX_EV = 8;
    localparam int MAXW   = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic token_in = 1'b0;
    logic id_always = 1'b0;
    logic [7:0] chip_id = 8'h00;
    logic [NUM_CH*4-1:0] ev_count;
    logic [5:0]  mem_ch;
    logic [3:0]  mem_ev;
    logic [11:0] mem_ts;
    logic [1:0]  mem_disc;
    logic sdata, tx_en, token_out;

    int cnt_b [NUM_CH];
    int salt = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) ev_count[c*4 +: 4] = 4'(cnt_b[c]);
    end

    function automatic logic [11:0] ts_of(int c, int e, int s);
        return 12'((c * 37 + e * 211 + s * 7) & 12'hFFF);
    endfunction
    function automatic logic [1:0] disc_of(int c, int e, int s);
        return 2'((c + e * 3 + s) & 3);
    endfunction
    function automatic logic [15:0] par(logic [15:0] w);
        return {w[15:1], ^w[15:1]};
    endfunction

    assign mem_ts   = ts_of(int'(mem_ch), int'(mem_ev), salt);
    assign mem_disc = disc_of(int'(mem_ch), int'(mem_ev), salt);

    zs_readout_serializer #(.NUM_CH(NUM_CH), .MAX_EV(MAX_EV)) u_dut (
        .clk(clk), .rst_n(rst_n), .token_in(token_in), .id_always(id_always),
        .chip_id(chip_id), .ev_count(ev_count), .mem_ch(mem_ch), .mem_ev(mem_ev),
        .mem_ts(mem_ts), .mem_disc(mem_disc), .sdata(sdata), .tx_en(tx_en),
        .token_out(token_out)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    logic [15:0] exp_w [MAXW];
    logic [15:0] act_w [MAXW];

    task automatic run_case(input string tag, input int inject);
        int n = 0;
        int nbits = 0;
        int cyc = 0;
        bit gap = 1'b0;
        bit quiet_ok = 1'b1;
        exp_w[n++] = par({1'b1, 6'b0, chip_id, 1'b0});
        for (int c = 0; c < NUM_CH; c++) begin
            int k = (cnt_b[c] > MAX_EV) ? MAX_EV : cnt_b[c];
            if (k > 0) begin
                exp_w[n++] = par({1'b1, 6'(c), 4'(k), 4'b0, 1'b0});
                for (int e = 0; e < k; e++)
                    exp_w[n++] = par({1'b0, ts_of(c, e, salt), disc_of(c, e, salt), 1'b0});
            end
        end
        if (n == 1 && !id_always) n = 0;
        for (int i = 0; i < MAXW; i++) act_w[i] = 16'h0;

        @(negedge clk) token_in = 1'b1;
        @(negedge clk) token_in = 1'b0;
        chk(tx_en == (n > 0), {tag, " R2 start"}, tx_en, n > 0);
        while (!token_out && cyc < 12000) begin
            if (tx_en) begin
                if (nbits < MAXW * 16) act_w[nbits / 16][15 - (nbits % 16)] = sdata;
                if (gap) gap = 1'b1;
                nbits++;
            end else begin
                if (sdata) quiet_ok = 1'b0;
                if (nbits > 0) gap = 1'b1;
            end
            if (cyc == inject) token_in = 1'b1;
            @(negedge clk);
            token_in = 1'b0;
            cyc++;
        end
        chk(cyc < 12000, {tag, " watchdog R10"}, cyc, 0);
        chk(!gap, {tag, " R2 contiguous tx_en"}, gap, 0);
        chk(quiet_ok, {tag, " R13 quiet line"}, quiet_ok, 1);
        chk(nbits == n * 16, {tag, " R6 bit count"}, nbits, n * 16);
        for (int i = 0; i < n && i < MAXW; i++) begin
            string t = (i == 0) ? " R3 id word" : (exp_w[i][15] ? " R4 header" : " R5 data");
            chk(act_w[i] == exp_w[i], {tag, t}, act_w[i], exp_w[i]);
            chk(^act_w[i] == 1'b0, {tag, " R7 parity"}, act_w[i], 0);
        end
        @(negedge clk);
        chk(!token_out, {tag, " R10 single pulse"}, token_out, 0);
        chk(!tx_en, {tag, " R12 no restart"}, tx_en, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_counts();
        for (int c = 0; c < NUM_CH; c++) cnt_b[c] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_counts();
        repeat (3) @(negedge clk);
        chk(!tx_en && !sdata && !token_out, "R1 reset outputs", {tx_en, sdata, token_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_en && !sdata && !token_out, "R1 after release", {tx_en, sdata, token_out}, 0);

        // R8: empty chip, no identity
        chip_id = 8'hA5; id_always = 1'b0;
        @(negedge clk) token_in = 1'b1;
        @(negedge clk) token_in = 1'b0;
        chk(!tx_en && token_out, "R8 immediate handoff", {tx_en, token_out}, 2'b01);
        @(negedge clk);
        chk(!token_out, "R8 R10 pulse width", token_out, 0);
        repeat (2) @(negedge clk);

        // R9: empty chip, identity only
        id_always = 1'b1;
        run_case("R9 id only", -1);

        // channel 63 only, full depth
        chip_id = 8'h3C; id_always = 1'b0; salt = 5;
        cnt_b[63] = 8;
        run_case("R6 top channel", -1);

        // R11 saturation
        clear_counts();
        cnt_b[0] = 15; cnt_b[17] = 9;
        run_case("R11 saturate", -1);

        // R12 token during readout
        clear_counts();
        cnt_b[4] = 3; cnt_b[40] = 2; salt = 9;
        run_case("R12 token mid-run", 30);

        // full length 577 words
        for (int c = 0; c < NUM_CH; c++) cnt_b[c] = 8;
        chip_id = 8'hFF; salt = 2;
        run_case("R2 full load", -1);

        // random sparse patterns
        for (int r = 0; r < 20; r++) begin
            for (int c = 0; c < NUM_CH; c++)
                cnt_b[c] = (($urandom % 8) == 0) ? int'($urandom % 16) : 0;
            chip_id   = 8'($urandom);
            id_always = 1'($urandom);
            salt      = int'($urandom % 50);
            run_case("R5 random", -1);
        end
        summary();
    end
endmodule